// File: doc/BRIEF.md
# Saturating Arithmetic and Clamp Unit

This block is a 32-bit combinational datapath that performs arithmetic and range limiting with saturation. An operation code selects one of ten functions: signed and unsigned add and subtract that clamp at the representable limits, a signed doubling that clamps, signed and unsigned clamping of one operand to a selectable bit width, dual 16-bit versions of the two clamping functions, and a wrapping add that only reports signed overflow. The result and a per-operation saturation indication appear in the same cycle as the inputs.

A sticky overflow flag accumulates the saturation events of every operation issued with the valid strobe. Once set, no operation can clear it. Only the dedicated clear input clears it, and that input wins over a simultaneous set. An execution pipeline uses the block by driving operands from its register read stage, taking the result in the same cycle, and sampling the flag whenever software asks for it.

Top module: `sat_clamp_unit`

## Requirements
- R1: Op code 1 (signed add) returns a+b. When a and b share a sign and the 32-bit sum has the other sign, it returns 0x7FFFFFFF if a is non-negative and 0x80000000 if a is negative, and raises sat_o.
- R2: Op code 2 (signed subtract) returns a-b. When a and b differ in sign and the 32-bit difference differs in sign from a, it returns the same sign-selected limit as R1 and raises sat_o.
- R3: Op code 3 (doubling of a) returns 0x7FFFFFFF with sat_o for signed a >= 0x40000000, and 0x80000000 with sat_o for signed a <= 0xC0000000 (that value included). Any other a gives a shifted left by one, with sat_o low.
- R4: Op code 4 (unsigned add) returns 0xFFFFFFFF with sat_o when a+b carries out of 32 bits. Op code 5 (unsigned subtract) returns 0 with sat_o when b > a. Otherwise each returns the plain result.
- R5: Op code 6 (signed clamp) takes n = width_i and clamps signed a into [-2^n, 2^n-1]. Out-of-range values give the nearer bound and raise sat_o. Width 0 keeps only 0 and -1, and width 31 never clamps.
- R6: Op code 7 (unsigned clamp) returns 0 for negative a and 2^n-1 for a above 2^n-1, raising sat_o in both cases. Otherwise it returns a.
- R7: Op codes 8 and 9 sign-extend bits 15:0 and bits 31:16 of a separately. They apply R5 (code 8) or R6 (code 9) to each half, place the low 16 bits of the low-half result in bits 15:0 and those of the high-half result in bits 31:16, and raise sat_o if either half clamps.
- R8: Op code 0 returns the wrapped 32-bit sum a+b and raises sat_o under the signed overflow condition of R1.
- R9: Op codes 10 to 15 return 0 with sat_o low.
- R10: q_o becomes 1 on the clock edge after any cycle with valid_i high and sat_o high. It does not change in response to operations issued with valid_i low.
- R11: Once q_o is 1 it stays 1 until q_clr_i is sampled high. q_clr_i clears q_o on the next edge, even if a saturating operation is issued in the same cycle.
- R12: While rst_n is low, q_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation issued this cycle; qualifies flag update |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 32 | First operand / value to clamp or double |
| b_i | input | 32 | Second operand for add and subtract |
| width_i | input | 5 | Clamp width n for codes 6 to 9 |
| q_clr_i | input | 1 | Synchronous clear of the sticky flag |
| res_o | output | 32 | Combinational result |
| sat_o | output | 1 | Combinational: this operation saturated or overflowed |
| q_o | output | 1 | Sticky saturation flag |

## Verification
The bound checker checks the flag on every cycle: it is set after a valid saturating operation, held while no clear arrives, cleared with priority by the clear input, and never rises without a cause. It also checks that saturated results of the add and subtract codes are the proper limits and that clamp results fit inside the selected width. Only the bench's sweeps can show that each result value is arithmetically exact. These sweeps cover operand pairs at the sign and carry boundaries and every width from 0 to 31 for all four clamp codes, including a saturation that only one half of a dual operation reaches.

// File: rtl/sat_pkg.sv
package sat_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_DETECT  = 4'd0,
    OP_SADD        = 4'd1,
    OP_SSUB        = 4'd2,
    OP_SDOUBLE     = 4'd3,
    OP_UADD        = 4'd4,
    OP_USUB        = 4'd5,
    OP_SCLAMP      = 4'd6,
    OP_UCLAMP      = 4'd7,
    OP_SCLAMP_DUAL = 4'd8,
    OP_UCLAMP_DUAL = 4'd9
  } sat_op_e;

endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sat_arith.sv
module sat_arith
  import sat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    res,
  output logic            sat
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum_w;
  logic [W:0]   diff_w;
  logic         add_ovf;
  logic         sub_ovf;
  logic [W-1:0] sign_lim;
  logic         dbl_hi;
  logic         dbl_lo;

  always_comb begin
    sum_w    = {1'b0, a} + {1'b0, b};
    diff_w   = {1'b0, a} - {1'b0, b};
    add_ovf  = (a[W-1] == b[W-1]) && (sum_w[W-1] != a[W-1]);
    sub_ovf  = (a[W-1] != b[W-1]) && (diff_w[W-1] != a[W-1]);
    sign_lim = a[W-1] ? NEG_LIM : POS_LIM;
    // at or above +2^(W-2)
    dbl_hi   = ~a[W-1] & a[W-2];
    // at or below -2^(W-2): pattern 10.. or exactly 1100..0
    dbl_lo   = a[W-1] & (~a[W-2] | (a[W-3:0] == '0));
  end

  always_comb begin
    res = '0;
    sat = 1'b0;
    case (op)
      OP_ADD_DETECT: begin
        res = sum_w[W-1:0];
        sat = add_ovf;
      end
      OP_SADD: begin
        res = add_ovf ? sign_lim : sum_w[W-1:0];
        sat = add_ovf;
      end
      OP_SSUB: begin
        res = sub_ovf ? sign_lim : diff_w[W-1:0];
        sat = sub_ovf;
      end
      OP_SDOUBLE: begin
        if (dbl_hi) begin
          res = POS_LIM;
          sat = 1'b1;
        end else if (dbl_lo) begin
          res = NEG_LIM;
          sat = 1'b1;
        end else begin
          res = {a[W-2:0], 1'b0};
        end
      end
      OP_UADD: begin
        res = sum_w[W] ? '1 : sum_w[W-1:0];
        sat = sum_w[W];
      end
      OP_USUB: begin
        res = diff_w[W] ? '0 : diff_w[W-1:0];
        sat = diff_w[W];
      end
      default: begin
        res = '0;
        sat = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_clamp_lane.sv
module sat_clamp_lane #(
  parameter int W     = 32,
  parameter int SEL_W = $clog2(W)
) (
  input  logic [W-1:0]     val,
  input  logic [SEL_W-1:0] n,
  input  logic             signed_mode,
  output logic [W-1:0]     res,
  output logic             sat
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]        mask;
  logic signed [W-1:0] sval;
  logic signed [W-1:0] top;
  logic                s_over;
  logic                s_under;
  logic                u_neg;
  logic                u_over;

  always_comb begin
    mask    = (ONE << n) - ONE;
    sval    = val;
    top     = sval >>> n;
    s_over  = ~top[W-1] & (top != '0);
    s_under = top[W-1] & (top != '1);
    u_neg   = val[W-1];
    u_over  = ~val[W-1] & (val > mask);
  end

  always_comb begin
    res = val;
    sat = 1'b0;
    if (signed_mode) begin
      if (s_over) begin
        res = mask;
        sat = 1'b1;
      end else if (s_under) begin
        res = ~mask;
        sat = 1'b1;
      end
    end else begin
      if (u_neg) begin
        res = '0;
        sat = 1'b1;
      end else if (u_over) begin
        res = mask;
        sat = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_width_unit.sv
module sat_width_unit #(
  parameter int W     = 32,
  parameter int SEL_W = $clog2(W),
  parameter int LANES = 2
) (
  input  logic [W-1:0]     a,
  input  logic [SEL_W-1:0] n,
  input  logic             signed_mode,
  input  logic             dual,
  output logic [W-1:0]     res,
  output logic             sat
);

  localparam int H = W / LANES;

  logic [W-1:0] lane_in  [LANES];
  logic [W-1:0] lane_res [LANES];
  logic [LANES-1:0] lane_sat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [H-1:0] part;
    assign part = a[g*H +: H];
    if (g == 0) begin : g_first
      assign lane_in[g] = dual ? {{(W-H){part[H-1]}}, part} : a;
    end else begin : g_other
      assign lane_in[g] = {{(W-H){part[H-1]}}, part};
    end
    sat_clamp_lane #(.W(W), .SEL_W(SEL_W)) lane_i (
      .val         (lane_in[g]),
      .n           (n),
      .signed_mode (signed_mode),
      .res         (lane_res[g]),
      .sat         (lane_sat[g])
    );
  end

  always_comb begin
    if (dual) begin
      for (int i = 0; i < LANES; i++) begin
        res[i*H +: H] = lane_res[i][H-1:0];
      end
      sat = |lane_sat;
    end else begin
      res = lane_res[0];
      sat = lane_sat[0];
    end
  end

endmodule

// File: rtl/sat_q_flag.sv
module sat_q_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic q
);

  logic q_r;
  logic q_nxt;
  logic q_en;

  always_comb begin
    q_en  = clr | set;
    q_nxt = q_r;
    if (clr) begin
      q_nxt = 1'b0;
    end else if (set) begin
      q_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (q_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/sat_clamp_unit.sv
module sat_clamp_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SEL_W-1:0]  width_i,
  input  logic              q_clr_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o,
  output logic              q_o
);

  logic              rst_sync_n;
  logic [DATA_W-1:0] arith_res;
  logic              arith_sat;
  logic [DATA_W-1:0] clamp_res;
  logic              clamp_sat;
  logic              is_arith;
  logic              is_clamp;
  logic              clamp_signed;
  logic              clamp_dual;

  always_comb begin
    is_arith     = (op_i <= OP_USUB);
    is_clamp     = (op_i >= OP_SCLAMP) && (op_i <= OP_UCLAMP_DUAL);
    clamp_signed = (op_i == OP_SCLAMP) || (op_i == OP_SCLAMP_DUAL);
    clamp_dual   = (op_i == OP_SCLAMP_DUAL) || (op_i == OP_UCLAMP_DUAL);
  end

  sat_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sat_arith #(.W(DATA_W)) arith_i (
    .op  (op_i),
    .a   (a_i),
    .b   (b_i),
    .res (arith_res),
    .sat (arith_sat)
  );

  sat_width_unit #(.W(DATA_W), .SEL_W(SEL_W), .LANES(2)) width_i0 (
    .a           (a_i),
    .n           (width_i),
    .signed_mode (clamp_signed),
    .dual        (clamp_dual),
    .res         (clamp_res),
    .sat         (clamp_sat)
  );

  always_comb begin
    if (is_arith) begin
      res_o = arith_res;
      sat_o = arith_sat;
    end else if (is_clamp) begin
      res_o = clamp_res;
      sat_o = clamp_sat;
    end else begin
      res_o = '0;
      sat_o = 1'b0;
    end
  end

  sat_q_flag q_flag_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (q_clr_i),
    .set   (valid_i & sat_o),
    .q     (q_o)
  );

endmodule

// File: rtl/sat_clamp_unit_chk.sv
module sat_clamp_unit_chk
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [SEL_W-1:0]  width_i,
  input logic              q_clr_i,
  input logic [DATA_W-1:0] res_o,
  input logic              sat_o,
  input logic              q_o
);

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] res_s;
  logic signed [DATA_W-1:0] res_top;
  assign res_s   = res_o;
  assign res_top = res_s >>> width_i;

  AST_Q_SET: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (valid_i && sat_o && !q_clr_i) |=> q_o); // R10

  AST_Q_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!q_o && !(valid_i && sat_o)) |=> !q_o); // R10

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (q_o && !q_clr_i) |=> q_o); // R11

  AST_Q_CLEAR: assert property (@(posedge clk) disable iff (!rst_ok_n)
    q_clr_i |=> !q_o); // R11

  AST_SADD_LIMIT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ((op_i == OP_SADD || op_i == OP_SSUB) && sat_o) |->
      (res_o == (a_i[DATA_W-1] ? NEG_LIM : POS_LIM))); // R1

  AST_UADD_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_UADD && sat_o) |-> (res_o == '1)); // R4

  AST_USUB_ZERO: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_USUB && sat_o) |-> (res_o == '0)); // R4

  AST_UCLAMP_FITS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_UCLAMP) |-> ((res_o >> width_i) == '0)); // R6

  AST_SCLAMP_FITS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i == OP_SCLAMP) |-> (res_top == '0 || res_top == '1)); // R5

  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (op_i > OP_UCLAMP_DUAL) |-> (res_o == '0 && !sat_o)); // R9

endmodule

bind sat_clamp_unit sat_clamp_unit_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .width_i  (width_i),
  .q_clr_i  (q_clr_i),
  .res_o    (res_o),
  .sat_o    (sat_o),
  .q_o      (q_o)
);

// File: tb/sat_clamp_unit_tb_top.sv
module sat_clamp_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic [4:0]  width_i;
  logic        q_clr_i;
  logic [31:0] res_o;
  logic        sat_o;
  logic        q_o;

  int checks;
  int fails;
  bit done;

  sat_clamp_unit dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .width_i (width_i),
    .q_clr_i (q_clr_i),
    .res_o   (res_o),
    .sat_o   (sat_o),
    .q_o     (q_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] val_at(int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'h0000_0002;
      3:  return 32'h7FFF_FFFF;
      4:  return 32'h8000_0000;
      5:  return 32'hFFFF_FFFF;
      6:  return 32'h4000_0000;
      7:  return 32'h3FFF_FFFF;
      8:  return 32'hC000_0000;
      9:  return 32'hC000_0001;
      10: return 32'hBFFF_FFFF;
      11: return 32'h0000_7FFF;
      12: return 32'h0000_8000;
      13: return 32'hFFFF_8000;
      14: return 32'h1234_5678;
      default: return 32'h8001_7FFF;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0:    return "R8";
      1:    return "R1";
      2:    return "R2";
      3:    return "R3";
      4, 5: return "R4";
      6:    return "R5";
      7:    return "R6";
      8, 9: return "R7";
      default: return "R9";
    endcase
  endfunction

  // clamp of a signed value to width n, arithmetic reference
  function automatic void clamp_ref(longint v, int n, bit sgn,
                                    output longint r, output bit s);
    longint hi;
    longint lo;
    hi = (longint'(1) << n) - 1;
    lo = -(longint'(1) << n);
    r = v;
    s = 1'b0;
    if (sgn) begin
      if (v > hi) begin r = hi; s = 1'b1; end
      else if (v < lo) begin r = lo; s = 1'b1; end
    end else begin
      if (v < 0) begin r = 0; s = 1'b1; end
      else if (v > hi) begin r = hi; s = 1'b1; end
    end
  endfunction

  function automatic void ref_model(int op, logic [31:0] a, logic [31:0] b, int n,
                                    output logic [31:0] r, output bit s);
    longint sa;
    longint sb;
    longint ua;
    longint ub;
    longint t;
    longint r0;
    longint r1;
    bit s0;
    bit s1;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'(a);
    ub = longint'(b);
    r = 32'h0;
    s = 1'b0;
    case (op)
      0: begin
        t = sa + sb;
        r = a + b;
        s = (t > 64'sh7FFF_FFFF) || (t < -64'sh8000_0000);
      end
      1, 2: begin
        t = (op == 1) ? sa + sb : sa - sb;
        r = t[31:0];
        if (t > 64'sh7FFF_FFFF) begin r = 32'h7FFF_FFFF; s = 1'b1; end
        else if (t < -64'sh8000_0000) begin r = 32'h8000_0000; s = 1'b1; end
      end
      3: begin
        t = sa * 2;
        r = t[31:0];
        if (sa >= 64'sh4000_0000) begin r = 32'h7FFF_FFFF; s = 1'b1; end
        else if (sa <= -64'sh4000_0000) begin r = 32'h8000_0000; s = 1'b1; end
      end
      4: begin
        t = ua + ub;
        if (t > 64'sh0FFFF_FFFF) begin r = 32'hFFFF_FFFF; s = 1'b1; end
        else r = t[31:0];
      end
      5: begin
        if (ub > ua) begin r = 32'h0; s = 1'b1; end
        else begin t = ua - ub; r = t[31:0]; end
      end
      6, 7: begin
        clamp_ref(sa, n, op == 6, r0, s0);
        r = r0[31:0];
        s = s0;
      end
      8, 9: begin
        clamp_ref(longint'($signed(a[15:0])), n, op == 8, r0, s0);
        clamp_ref(longint'($signed(a[31:16])), n, op == 8, r1, s1);
        r = {r1[15:0], r0[15:0]};
        s = s0 | s1;
      end
      default: begin
        r = 32'h0;
        s = 1'b0;
      end
    endcase
  endfunction

  task automatic check_comb(int op, logic [31:0] a, logic [31:0] b, int n);
    logic [31:0] exp_r;
    bit exp_s;
    op_i    = op[3:0];
    a_i     = a;
    b_i     = b;
    width_i = n[4:0];
    #1;
    ref_model(op, a, b, n, exp_r, exp_s);
    checks++;
    if (res_o !== exp_r || sat_o !== exp_s) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h n=%0d: actual res=%h sat=%b expected res=%h sat=%b",
               tag_of(op), op, a, b, n, res_o, sat_o, exp_r, exp_s);
    end
  endtask

  task automatic check_q(string tag, bit exp_q);
    checks++;
    if (q_o !== exp_q) begin
      fails++;
      $display("FAIL %s q_o: actual %b expected %b", tag, q_o, exp_q);
    end
  endtask

  task automatic issue(bit v, bit clr, int op, logic [31:0] a, logic [31:0] b, int n);
    @(negedge clk);
    valid_i = v;
    q_clr_i = clr;
    op_i    = op[3:0];
    a_i     = a;
    b_i     = b;
    width_i = n[4:0];
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    q_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    checks  = 0;
    fails   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    valid_i = 1'b0;
    q_clr_i = 1'b0;
    op_i    = 4'd0;
    a_i     = 32'h0;
    b_i     = 32'h0;
    width_i = 5'd0;
    repeat (3) @(negedge clk);
    check_q("R12", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_q("R12", 1'b0);

    // two-operand codes R8 R1 R2 R3 R4 over all value pairs
    for (int op = 0; op <= 5; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          check_comb(op, val_at(i), val_at(j), 0);
        end
      end
    end
    // clamp codes R5 R6 R7 over every width, 0 and 31 included
    for (int op = 6; op <= 9; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int n = 0; n < 32; n++) begin
          check_comb(op, val_at(i), 32'h0, n);
        end
      end
    end
    // unused codes R9
    for (int op = 10; op <= 15; op++) begin
      for (int i = 0; i < 16; i++) begin
        check_comb(op, val_at(i), val_at(15 - i), 3);
      end
    end

    // sticky flag behaviour
    issue(1'b1, 1'b0, 1, 32'h1, 32'h2, 0);
    check_q("R10", 1'b0);
    issue(1'b0, 1'b0, 1, 32'h7FFF_FFFF, 32'h1, 0);
    check_q("R10", 1'b0);
    issue(1'b1, 1'b0, 1, 32'h7FFF_FFFF, 32'h1, 0);
    check_q("R10", 1'b1);
    issue(1'b1, 1'b0, 4, 32'h1, 32'h1, 0);
    check_q("R11", 1'b1);
    issue(1'b1, 1'b0, 7, 32'h3, 32'h0, 4);
    check_q("R11", 1'b1);
    issue(1'b0, 1'b1, 0, 32'h0, 32'h0, 0);
    check_q("R11", 1'b0);
    issue(1'b1, 1'b1, 5, 32'h0, 32'h1, 0);
    check_q("R11", 1'b0);
    // only the high half saturates
    issue(1'b1, 1'b0, 9, 32'hFFFF_0005, 32'h0, 8);
    check_q("R7", 1'b1);
    issue(1'b0, 1'b1, 0, 32'h0, 32'h0, 0);
    check_q("R11", 1'b0);
    issue(1'b1, 1'b0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    check_q("R8", 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check_q("R12", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end

endmodule